// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers the five pipeline registers of an in-order processor: fetch (F), decode (D), execute (E), memory (M) and write-back (W). Each cycle it examines the instruction records held in the D, E and M registers, together with the branch condition the execute stage has just evaluated. It then decides, for every stage register, whether that register loads its input, holds its value, or takes in a no-op at the next rising edge.

Three situations are recognised. The first is a load whose result is needed too early by the instruction behind it. The second is a return instruction whose target is not yet known. The third is a conditional jump that was predicted taken but is found not taken. When several occur in the same cycle, fixed priority rules combine them. The block contains the five stage registers, so their contents can be seen directly at the ports.

An instruction record is 28 bits wide with the default 8-bit tag. The fields are: [27:24] operation class, [23:20] first source register, [19:16] second source register, [15:12] ALU destination, [11:8] memory destination, [7:0] free tag. Operation classes: 0x1 no-op, 0x5 memory load, 0xB stack pop, 0x9 return, 0x7 conditional jump, 0x6 ALU operation. Register ID 0xF means no register. The bubble record is 0x1FFFF00. Control vectors use bit 0 = F, 1 = D, 2 = E, 3 = M, 4 = W.

Top module: `hz_ctrl_unit`

## Requirements
- R1: While reset is low at a rising edge, D, E, M and W take the bubble record 0x1FFFF00 and F takes the reset PC (0). With an empty pipeline, every stall and bubble bit is 0.
- R2: A load-use hazard exists when the E record has class load (0x5) or pop (0xB) and its memory destination equals either source of the D record. It sets stall on F and D, bubble on E, and leaves M and W normal.
- R3: Register ID 0xF never matches, even when the E memory destination and a D source are both 0xF.
- R4: A return (class 0x9) in D, E or M, with no load-use hazard, sets stall on F and bubble on D, and leaves E, M and W normal.
- R5: When the E record is a conditional jump (0x7) and exe_cond is 0, D and E are bubbled and F, M and W are normal.
- R6: A return in flight together with a mispredicted jump gives F stall and bubbles on D and E.
- R7: A return in flight together with a load-use hazard gives the load-use action: D is stalled and not bubbled, and E is bubbled.
- R8: On each rising edge, a normal stage loads its input, a stalled stage keeps its value, and a bubbled stage loads the bubble record. M and W always load.
- R9: No other situation stalls or bubbles any stage. This covers a non-load whose memory destination matches a D source, and a jump with exe_cond 1.
- R10: No stage is ever given stall and bubble in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| next_pc | input | PC_W | Predicted PC offered to the F register |
| pc_q | output | PC_W | Current F register value |
| dec_in | input | REC_W | Record offered to the D register |
| dec_q | output | REC_W | Current D register record |
| exe_in | input | REC_W | Record offered to the E register |
| exe_q | output | REC_W | Current E register record |
| mem_in | input | REC_W | Record offered to the M register |
| mem_q | output | REC_W | Current M register record |
| wb_in | input | REC_W | Record offered to the W register |
| wb_q | output | REC_W | Current W register record |
| exe_cond | input | 1 | Condition result for the instruction now in E |
| stage_stall | output | 5 | Per-stage stall request, bit 0 = F |
| stage_bubble | output | 5 | Per-stage bubble request, bit 0 = F |

## Verification
The bench walks a cross product of the operation class in E, D and M, the E memory destination (0xF or a real register), the two D sources (matching, non-matching, 0xF) and both condition values. This crosses every pair of situations, so a wrong priority between a return and a load-use hazard, or between a return and a mispredict, shows up in a case distinct from the single-hazard ones. Non-load classes with a matching destination, and a taken jump, separate true triggers from look-alikes. After each control check the stage registers are clocked once with fresh inputs, which tells hold, load and no-op apart by their contents.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard control unit: operation classes, the
// "no register" ID, stage indices and the record header layout.
// Assumes 4-bit operation classes and 4-bit register IDs.
package hz_pkg;

    localparam int OP_W   = 4;
    localparam int REG_W  = 4;
    localparam int NUM_ST = 5;

    localparam int ST_F = 0;
    localparam int ST_D = 1;
    localparam int ST_E = 2;
    localparam int ST_M = 3;
    localparam int ST_W = 4;

    localparam logic [REG_W-1:0] REG_NONE = '1;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'h1,
        OP_LOAD   = 4'h5,
        OP_ALU    = 4'h6,
        OP_BRANCH = 4'h7,
        OP_RETURN = 4'h9,
        OP_POP    = 4'hB
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst_e;
        logic [REG_W-1:0] dst_m;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    localparam hdr_t HDR_BUBBLE = '{op: OP_NOP, src_a: REG_NONE, src_b: REG_NONE,
                                    dst_e: REG_NONE, dst_m: REG_NONE};

    // True for classes that write a register from data memory.
    function automatic logic reads_memory(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_POP);
    endfunction

endpackage

// File: rtl/hz_detect.sv
// Hazard detection: flags load-use, return in flight and mispredicted
// conditional jump from the D/E/M headers and the execute condition.
// Assumes REG_NONE never denotes a real register.
module hz_detect
    import hz_pkg::*;
(
    input  logic [OP_W-1:0]  dec_op,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [OP_W-1:0]  exe_op,
    input  logic [REG_W-1:0] exe_dst_m,
    input  logic [OP_W-1:0]  mem_op,
    input  logic             exe_cond,
    output logic             load_use,
    output logic             ret_pending,
    output logic             br_mispredict
);

    logic dst_valid;
    logic src_hit;

    // Compare the memory destination in E with both decode sources.
    always_comb begin
        dst_valid = (exe_dst_m != REG_NONE);
        src_hit   = dst_valid && ((exe_dst_m == dec_src_a) || (exe_dst_m == dec_src_b));
        load_use  = reads_memory(exe_op) && src_hit;
    end

    // A return anywhere between decode and memory blocks fetch.
    always_comb begin
        ret_pending = (dec_op == OP_RETURN) || (exe_op == OP_RETURN) || (mem_op == OP_RETURN);
    end

    // Predicted-taken jump whose condition came out false.
    always_comb begin
        br_mispredict = (exe_op == OP_BRANCH) && !exe_cond;
    end

endmodule

// File: rtl/hz_action.sv
// Action tables: turns the three hazard flags into per-stage stall and
// bubble requests, with load-use taking priority over return in decode.
// Assumes a load and a jump never sit in E together.
module hz_action
    import hz_pkg::*;
(
    input  logic              load_use,
    input  logic              ret_pending,
    input  logic              br_mispredict,
    output logic [NUM_ST-1:0] stall,
    output logic [NUM_ST-1:0] bubble
);

    // Merge the per-condition tables into one control word per stage.
    always_comb begin
        stall  = '0;
        bubble = '0;
        stall[ST_F]  = load_use || ret_pending;
        stall[ST_D]  = load_use;
        bubble[ST_D] = br_mispredict || (ret_pending && !load_use);
        bubble[ST_E] = br_mispredict || load_use;
    end

endmodule

// File: rtl/hz_pipe_reg.sv
// Stage register with three update modes: load, hold (stall) and
// insert no-op (bubble). Bubble wins over stall. Reset loads BUBBLE_VAL.
module hz_pipe_reg #(
    parameter int             W          = 8,
    parameter logic [W-1:0]   BUBBLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    // Select the next value according to the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= BUBBLE_VAL;
        else if (bubble)  q_r <= BUBBLE_VAL;
        else if (!stall)  q_r <= d;
    end

    assign q = q_r;

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (q == BUBBLE_VAL));

    assert_bubble_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (q == BUBBLE_VAL));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bubble) |=> $stable(q));

    assert_normal_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !bubble) |=> (q == $past(d)));

endmodule

// File: rtl/hz_ctrl_unit.sv
// Top: five stage registers plus hazard detection and action logic.
// Control is combinational from the stored D/E/M records and takes
// effect at the next rising edge. Record = {header, tag}.
module hz_ctrl_unit
    import hz_pkg::*;
#(
    parameter int              TAG_W    = 8,
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] PC_RESET = '0,
    localparam int             REC_W    = HDR_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   next_pc,
    output logic [PC_W-1:0]   pc_q,
    input  logic [REC_W-1:0]  dec_in,
    output logic [REC_W-1:0]  dec_q,
    input  logic [REC_W-1:0]  exe_in,
    output logic [REC_W-1:0]  exe_q,
    input  logic [REC_W-1:0]  mem_in,
    output logic [REC_W-1:0]  mem_q,
    input  logic [REC_W-1:0]  wb_in,
    output logic [REC_W-1:0]  wb_q,
    input  logic              exe_cond,
    output logic [NUM_ST-1:0] stage_stall,
    output logic [NUM_ST-1:0] stage_bubble
);

    localparam logic [REC_W-1:0] BUBBLE_REC = {HDR_BUBBLE, {TAG_W{1'b0}}};

    logic [REC_W-1:0] rec_in [ST_D:ST_W];
    logic [REC_W-1:0] rec_q  [ST_D:ST_W];
    hdr_t             dec_hdr, exe_hdr, mem_hdr;
    logic             lu_flag, ret_flag, mis_flag;

    assign rec_in[ST_D] = dec_in;
    assign rec_in[ST_E] = exe_in;
    assign rec_in[ST_M] = mem_in;
    assign rec_in[ST_W] = wb_in;

    assign dec_q = rec_q[ST_D];
    assign exe_q = rec_q[ST_E];
    assign mem_q = rec_q[ST_M];
    assign wb_q  = rec_q[ST_W];

    // Fetch register holds the predicted PC; it is never bubbled in practice.
    hz_pipe_reg #(.W(PC_W), .BUBBLE_VAL(PC_RESET)) u_fetch_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stage_stall[ST_F]),
        .bubble (stage_bubble[ST_F]),
        .d      (next_pc),
        .q      (pc_q)
    );

    // One instruction-record register per later stage.
    for (genvar s = ST_D; s <= ST_W; s++) begin : g_stage
        hz_pipe_reg #(.W(REC_W), .BUBBLE_VAL(BUBBLE_REC)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .stall  (stage_stall[s]),
            .bubble (stage_bubble[s]),
            .d      (rec_in[s]),
            .q      (rec_q[s])
        );
    end

    assign dec_hdr = hdr_t'(rec_q[ST_D][REC_W-1 -: HDR_W]);
    assign exe_hdr = hdr_t'(rec_q[ST_E][REC_W-1 -: HDR_W]);
    assign mem_hdr = hdr_t'(rec_q[ST_M][REC_W-1 -: HDR_W]);

    hz_detect u_detect (
        .dec_op        (dec_hdr.op),
        .dec_src_a     (dec_hdr.src_a),
        .dec_src_b     (dec_hdr.src_b),
        .exe_op        (exe_hdr.op),
        .exe_dst_m     (exe_hdr.dst_m),
        .mem_op        (mem_hdr.op),
        .exe_cond      (exe_cond),
        .load_use      (lu_flag),
        .ret_pending   (ret_flag),
        .br_mispredict (mis_flag)
    );

    hz_action u_action (
        .load_use      (lu_flag),
        .ret_pending   (ret_flag),
        .br_mispredict (mis_flag),
        .stall         (stage_stall),
        .bubble        (stage_bubble)
    );

    assert_lu_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lu_flag |-> (stage_stall[ST_F] && stage_stall[ST_D] && stage_bubble[ST_E]));

    assert_none_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_hdr.dst_m == REG_NONE) |-> !lu_flag);

    assert_ret_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_flag && !lu_flag) |-> (stage_stall[ST_F] && stage_bubble[ST_D]));

    assert_mis_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mis_flag |-> (stage_bubble[ST_D] && stage_bubble[ST_E] && !stage_stall[ST_D]));

    assert_ret_lu_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_flag && lu_flag) |=> $stable(dec_q));

    assert_mis_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mis_flag |=> (dec_q == BUBBLE_REC && exe_q == BUBBLE_REC));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stage_stall & stage_bubble) == 0);

endmodule

// File: tb/hz_ctrl_unit_tb.sv
// Near-exhaustive sweep of D/E/M operation classes, register IDs and the
// branch condition; expected control and register contents are computed
// from the requirement equations.
module hz_ctrl_unit_tb_top;

    localparam int CLK_P   = 10;
    localparam int WD_LIM  = 150000;
    localparam logic [27:0] NOP_REC = 28'h1FFFF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] next_pc = '0;
    logic [15:0] pc_q;
    logic [27:0] dec_in = '0, exe_in = '0, mem_in = '0, wb_in = '0;
    logic [27:0] dec_q, exe_q, mem_q, wb_q;
    logic        exe_cond = 1'b0;
    logic [4:0]  stage_stall, stage_bubble;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    hz_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .next_pc(next_pc), .pc_q(pc_q),
        .dec_in(dec_in), .dec_q(dec_q),
        .exe_in(exe_in), .exe_q(exe_q),
        .mem_in(mem_in), .mem_q(mem_q),
        .wb_in(wb_in), .wb_q(wb_q),
        .exe_cond(exe_cond),
        .stage_stall(stage_stall), .stage_bubble(stage_bubble)
    );

    function automatic logic [27:0] mk(input logic [3:0] op, input logic [3:0] sa,
                                       input logic [3:0] sb, input logic [3:0] de,
                                       input logic [3:0] dm, input logic [7:0] tag);
        return {op, sa, sb, de, dm, tag};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] e_op_of(input int i);
        case (i)
            0: return 4'h1; 1: return 4'h5; 2: return 4'hB;
            3: return 4'h9; 4: return 4'h7; default: return 4'h6;
        endcase
    endfunction

    function automatic logic [3:0] dm_op_of(input int i);
        case (i)
            0: return 4'h1; 1: return 4'h9; default: return 4'h6;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] eop, dop, mop, edm, dsa, dsb;
        logic lu, rt, ms;
        logic [4:0] xs, xb;
        logic [27:0] drec, erec, mrec, wrec, drec2, erec2, mrec2, wrec2;
        logic [15:0] pc0, pc1;
        string tag;
        int n;
        n = 0;

        // R1: reset state
        @(negedge clk); @(negedge clk);
        chk("R1", "pc", {16'h0, pc_q}, 32'h0);
        chk("R1", "dec", {4'h0, dec_q}, {4'h0, NOP_REC});
        chk("R1", "exe", {4'h0, exe_q}, {4'h0, NOP_REC});
        chk("R1", "mem", {4'h0, mem_q}, {4'h0, NOP_REC});
        chk("R1", "wb",  {4'h0, wb_q},  {4'h0, NOP_REC});
        chk("R1", "ctl", {22'h0, stage_stall, stage_bubble}, 32'h0);

        for (int ie = 0; ie < 6; ie++)
        for (int id = 0; id < 3; id++)
        for (int im = 0; im < 3; im++)
        for (int iw = 0; iw < 3; iw++)
        for (int ia = 0; ia < 2; ia++)
        for (int ib = 0; ib < 3; ib++)
        for (int ic = 0; ic < 2; ic++) begin
            eop = e_op_of(ie); dop = dm_op_of(id); mop = dm_op_of(im);
            edm = (iw == 0) ? 4'hF : (iw == 1) ? 4'h3 : 4'h5;
            dsa = (ia == 0) ? 4'h3 : 4'hF;
            dsb = (ib == 0) ? 4'h5 : (ib == 1) ? 4'hF : 4'h3;
            n++;
            pc0 = 16'(n * 2);   pc1 = 16'(n * 2 + 1);
            drec = mk(dop, dsa, dsb, 4'h6, 4'hF, 8'(n));
            erec = mk(eop, 4'hF, 4'hF, 4'h2, edm, 8'(n + 1));
            mrec = mk(mop, 4'hF, 4'hF, 4'hF, 4'hF, 8'(n + 2));
            wrec = mk(4'h6, 4'hF, 4'hF, 4'h4, 4'hF, 8'(n + 3));
            drec2 = mk(4'h6, 4'h1, 4'h2, 4'h7, 4'hF, 8'(n + 4));
            erec2 = mk(4'h6, 4'h1, 4'h1, 4'h8, 4'hF, 8'(n + 5));
            mrec2 = mk(4'h1, 4'hF, 4'hF, 4'hF, 4'hF, 8'(n + 6));
            wrec2 = mk(4'h6, 4'hF, 4'hF, 4'h9, 4'hF, 8'(n + 7));

            // Release reset and offer state A; the empty pipeline loads it.
            rst_n = 1'b1;
            next_pc = pc0; dec_in = drec; exe_in = erec; mem_in = mrec; wb_in = wrec;
            exe_cond = ic[0];
            @(negedge clk);

            lu = ((eop == 4'h5) || (eop == 4'hB)) && (edm != 4'hF) &&
                 ((edm == dsa) || (edm == dsb));
            rt = (dop == 4'h9) || (eop == 4'h9) || (mop == 4'h9);
            ms = (eop == 4'h7) && !ic[0];
            xs = {3'b000, lu, lu | rt};
            xb = {2'b00, ms | lu, ms | (rt & !lu), 1'b0};
            if (lu && rt)                                    tag = "R7";
            else if (rt && ms)                               tag = "R6";
            else if (lu)                                     tag = "R2";
            else if (rt)                                     tag = "R4";
            else if (ms)                                     tag = "R5";
            else if ((eop == 4'h5 || eop == 4'hB) && edm == 4'hF) tag = "R3";
            else                                             tag = "R9";
            chk(tag, "stall", {27'h0, stage_stall}, {27'h0, xs});
            chk(tag, "bubble", {27'h0, stage_bubble}, {27'h0, xb});
            chk("R10", "overlap", {27'h0, stage_stall & stage_bubble}, 32'h0);

            // Offer state B and clock once under the control just checked.
            next_pc = pc1; dec_in = drec2; exe_in = erec2; mem_in = mrec2; wb_in = wrec2;
            @(negedge clk);
            chk("R8", "pc", {16'h0, pc_q}, {16'h0, xs[0] ? pc0 : pc1});
            chk("R8", "dec", {4'h0, dec_q},
                {4'h0, xb[1] ? NOP_REC : (xs[1] ? drec : drec2)});
            chk("R8", "exe", {4'h0, exe_q}, {4'h0, xb[2] ? NOP_REC : erec2});
            chk("R8", "mem", {4'h0, mem_q}, {4'h0, mrec2});
            chk("R8", "wb",  {4'h0, wb_q},  {4'h0, wrec2});

            // Empty the pipeline for the next case (R1 reset path).
            rst_n = 1'b0;
            @(negedge clk);
            chk("R1", "dec_reset", {4'h0, dec_q}, {4'h0, NOP_REC});
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule